// File: doc/BRIEF.md
# Bidirectional On-the-fly AES Round-Key Generator

This block turns a 128-, 192- or 256-bit AES cipher key into its sequence of 128-bit round keys. It produces one round key per request and computes it from the previous one, so no full schedule is ever stored. In the encrypt direction it walks from round 0 upward. In the decrypt direction it walks from the final round downward, rebuilding each earlier key from the later words.

All key lengths share one generator. That generator turns out four new schedule words per step and uses a single four-S-box SubWord unit. For 256-bit keys, each step is one half of the eight-word schedule window, so one SubWord serves both halves.

When a forward walk reaches the final round key, the block saves the whole schedule window and a tag made from the key. A later decrypt start with the same key and length then begins at the final round key after a single cycle. On a miss, the block first runs the forward walk internally, one step per cycle, and then presents the final key.

Top module: `aes_rkey_gen`

## Requirements
- R1: While reset is asserted and after its release, `rk_valid` is 0 until the first `start`.
- R2: Key word j lies on `cipher_key[255-32j -: 32]`. `key_size` 0 selects 128 bits (words 0–3), 1 selects 192 bits (words 0–5) and 2 selects 256 bits (words 0–7). A `start` with `decrypt`=0 makes `rk_valid` 1 after that clock edge, with `round_key` = {word0,word1,word2,word3}, the round-0 key.
- R3: With `key_size`=0, each `step` in the encrypt direction presents the next standard round key, so rounds 1 to 10 follow in order.
- R4: With `key_size`=1, each encrypt `step` presents the next round key, so rounds 1 to 12 follow in order.
- R5: With `key_size`=2, each encrypt `step` presents the next round key, so rounds 1 to 14 follow in order.
- R6: A `step` while the final round key is shown in the encrypt direction leaves `round_key` unchanged.
- R7: A `start` with `decrypt`=1 that misses the saved key drops `rk_valid`. `rk_valid` rises on the Nr+1-th rising edge, counting the edge that samples `start` (Nr = 10/12/14). At that point `round_key` is the round-Nr key.
- R8: In the decrypt direction, each `step` presents the previous round key, down to round 0. A `step` at round 0 leaves `round_key` unchanged.
- R9: A forward walk reaching the final round, whether stepped or internal, saves the key. A later `start` with `decrypt`=1, the same key and the same `key_size` then raises `rk_valid` after one edge, showing the round-Nr key.
- R10: The saved-key match compares `key_size` and only the key words that size uses. A difference in a used bit or in the size takes the R7 path. Bits outside the used words do not prevent a match.
- R11: With `start` and `step` both low, `rk_valid` and `round_key` hold their values.
- R12: `step` has no effect while the internal forward pre-expansion runs: the latency and the key from R7 are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cipher_key | input | 256 | Cipher key, word 0 in the top bits |
| key_size | input | 2 | 0: 128-bit, 1: 192-bit, 2: 256-bit |
| decrypt | input | 1 | Direction sampled at start: 0 forward, 1 backward |
| start | input | 1 | Begin a new walk with the current key, size and direction |
| step | input | 1 | Advance to the next round key in the chosen direction |
| round_key | output | 128 | Current round key, word order high to low |
| rk_valid | output | 1 | round_key holds a round key of the current walk |

## Verification
The block has no parameters, so the bench builds it as it stands, with the fixed AES sizes. That covers all three schedule shapes: the four-word window, the six-word window whose rotate points drift across step boundaries, and the eight-word window with its extra SubWord in the upper half. For each size, the bench walks the full schedule in both directions. It checks the saved-window path and the pre-expansion path, which together exercise every Rcon index in both directions. It also checks the tag match against single-bit, unused-bit and size differences.

// File: rtl/aes_rkey_gen.sv
module aes_rkey_gen (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [255:0] cipher_key,
  input  logic [1:0]   key_size,
  input  logic         decrypt,
  input  logic         start,
  input  logic         step,
  output logic [127:0] round_key,
  output logic         rk_valid
);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_PRE = 2'd1, S_RUN = 2'd2} st_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    xt = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int n = 0; n < 8; n++) begin
      if (b[n]) p = p ^ x;
      x = xt(x);
    end
    gmul = p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] sq, inv;
    sq = a;
    inv = 8'h01;
    for (int n = 0; n < 7; n++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    sbox = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] x);
    subw = {sbox(x[31:24]), sbox(x[23:16]), sbox(x[15:8]), sbox(x[7:0])};
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int n = 1; n < 11; n++)
      if (4'(n) < idx) r = xt(r);
    rcon = r;
  endfunction

  function automatic logic [3:0] nk_of(input logic [1:0] kl);
    case (kl)
      2'd0:    nk_of = 4'd4;
      2'd1:    nk_of = 4'd6;
      default: nk_of = 4'd8;
    endcase
  endfunction

  function automatic logic [6:0] last_of(input logic [1:0] kl);
    case (kl)
      2'd0:    last_of = 7'd44;
      2'd1:    last_of = 7'd54;
      default: last_of = 7'd64;
    endcase
  endfunction

  function automatic logic rot_at(input logic [6:0] i, input logic [1:0] kl);
    case (kl)
      2'd0:    rot_at = (i[1:0] == 2'd0);
      2'd1:    rot_at = ((i % 7'd6) == 7'd0);
      default: rot_at = (i[2:0] == 3'd0);
    endcase
  endfunction

  function automatic logic sub_at(input logic [6:0] i, input logic [1:0] kl);
    sub_at = kl[1] && (i[2:0] == 3'd4);
  endfunction

  function automatic logic [3:0] rc_idx(input logic [6:0] i, input logic [1:0] kl);
    logic [6:0] q;
    case (kl)
      2'd0:    q = i >> 2;
      2'd1:    q = i / 7'd6;
      default: q = i >> 3;
    endcase
    rc_idx = q[3:0];
  endfunction

  st_t          st;
  logic [6:0]   e;
  logic [1:0]   kl_q;
  logic         dir_q;
  logic [31:0]  win  [8];
  logic [31:0]  bwin [8];
  logic [255:0] btag;
  logic [1:0]   blen;
  logic         bval;

  logic [255:0] kmask;
  logic [31:0]  kin  [8];
  logic [31:0]  nwin [8];
  logic [31:0]  sw_in, sw_out;
  logic         sp_en, sp_rot;
  logic [1:0]   sp_k;
  logic [7:0]   sp_rc;
  int           nk;
  logic [6:0]   e_last;
  logic         mv_back, fwd_go, back_go, at_last, at_first, hit;

  always_comb begin
    case (key_size)
      2'd0:    kmask = {cipher_key[255:128], 128'h0};
      2'd1:    kmask = {cipher_key[255:64], 64'h0};
      default: kmask = cipher_key;
    endcase
    for (int j = 0; j < 8; j++) kin[j] = kmask[255-32*j -: 32];
  end

  assign nk       = int'(nk_of(kl_q));
  assign e_last   = last_of(kl_q);
  assign at_last  = (e == e_last);
  assign at_first = (e == 7'(nk_of(kl_q)));
  assign mv_back  = (st == S_RUN) && dir_q;
  assign fwd_go   = (st == S_PRE) || ((st == S_RUN) && !dir_q && step);
  assign back_go  = (st == S_RUN) && dir_q && step;
  assign hit      = bval && (blen == key_size) && (btag == kmask);

  always_comb begin : pass1
    logic [31:0] a [4];
    logic [31:0] pv;
    logic [6:0]  i;
    for (int k = 0; k < 4; k++) a[k] = '0;
    sw_in = '0; sp_en = 1'b0; sp_k = '0; sp_rot = 1'b0; sp_rc = '0;
    for (int k = 0; k < 4; k++) begin
      if (!mv_back) begin
        i = e + 7'(k);
        if (k == 0) pv = win[nk-1];
        else        pv = a[(k-1) & 3];
        a[k] = win[k] ^ pv;
      end else begin
        i = e - 7'd1 - 7'(k);
        if (nk - 2 - k >= 0) pv = win[nk-2-k];
        else                 pv = a[0];
        a[k] = win[nk-1-k] ^ pv;
      end
      if (!sp_en && (rot_at(i, kl_q) || sub_at(i, kl_q))) begin
        sp_en  = 1'b1;
        sp_k   = 2'(k);
        sp_rot = rot_at(i, kl_q);
        sp_rc  = sp_rot ? rcon(rc_idx(i, kl_q)) : 8'h00;
        sw_in  = sp_rot ? {pv[23:0], pv[31:24]} : pv;
      end
    end
  end

  assign sw_out = subw(sw_in);

  always_comb begin : pass2
    logic [31:0] w [4];
    logic [31:0] pv;
    for (int k = 0; k < 4; k++) w[k] = '0;
    for (int k = 0; k < 4; k++) begin
      if (!mv_back) begin
        if (k == 0) pv = win[nk-1];
        else        pv = w[(k-1) & 3];
      end else begin
        if (nk - 2 - k >= 0) pv = win[nk-2-k];
        else                 pv = w[0];
      end
      if (sp_en && sp_k == 2'(k)) pv = sw_out ^ {sp_rc, 24'h0};
      if (!mv_back) w[k] = win[k] ^ pv;
      else          w[k] = win[nk-1-k] ^ pv;
    end
    for (int j = 0; j < 8; j++) begin
      nwin[j] = '0;
      if (!mv_back) begin
        if (j < 4 && j < nk - 4) nwin[j] = win[(j+4) & 7];
        else if (j < nk)         nwin[j] = w[(j-(nk-4)) & 3];
      end else begin
        if (j < 4)       nwin[j] = w[3-j];
        else if (j < nk) nwin[j] = win[j-4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      e     <= '0;
      kl_q  <= '0;
      dir_q <= 1'b0;
      btag  <= '0;
      blen  <= '0;
      bval  <= 1'b0;
      for (int j = 0; j < 8; j++) begin
        win[j]  <= '0;
        bwin[j] <= '0;
      end
    end else if (start) begin
      kl_q  <= key_size;
      dir_q <= decrypt;
      if (decrypt && hit) begin
        for (int j = 0; j < 8; j++) win[j] <= bwin[j];
        e  <= last_of(key_size);
        st <= S_RUN;
      end else begin
        for (int j = 0; j < 8; j++) win[j] <= kin[j];
        e  <= 7'(nk_of(key_size));
        st <= decrypt ? S_PRE : S_RUN;
        if (!hit) begin
          btag <= kmask;
          blen <= key_size;
          bval <= 1'b0;
        end
      end
    end else if (fwd_go && !at_last) begin
      for (int j = 0; j < 8; j++) win[j] <= nwin[j];
      e <= e + 7'd4;
      if (e + 7'd4 == e_last) begin
        for (int j = 0; j < 8; j++) bwin[j] <= nwin[j];
        bval <= 1'b1;
        st   <= S_RUN;
      end
    end else if (back_go && !at_first) begin
      for (int j = 0; j < 8; j++) win[j] <= nwin[j];
      e <= e - 7'd4;
    end
  end

  assign round_key = {win[0], win[1], win[2], win[3]};
  assign rk_valid  = (st == S_RUN);

endmodule

module aes_rkey_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         decrypt,
  input logic         step,
  input logic         rk_valid,
  input logic [127:0] round_key,
  input logic         hit,
  input logic         dir_q,
  input logic         at_last,
  input logic         at_first
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rk_valid);

  assert_enc_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !decrypt) |=> rk_valid);

  assert_end_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && !start && step && !dir_q && at_last) |=> $stable(round_key));

  assert_miss_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && decrypt && !hit) |=> !rk_valid);

  assert_first_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && !start && step && dir_q && at_first) |=> $stable(round_key));

  assert_hit_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && decrypt && hit) |=> rk_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid && !start && !step) |=> (rk_valid && $stable(round_key)));

endmodule

bind aes_rkey_gen aes_rkey_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .step(step),
  .rk_valid(rk_valid), .round_key(round_key), .hit(hit), .dir_q(dir_q),
  .at_last(at_last), .at_first(at_first)
);

// File: tb/aes_rkey_gen_tb.sv
module aes_rkey_gen_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [255:0] VKEY [3] = '{
    256'h2b7e151628aed2a6abf7158809cf4f3c_00000000000000000000000000000000,
    256'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b_0000000000000000,
    256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4
  };
  localparam logic [1:0]   VSIZE [3] = '{2'd0, 2'd1, 2'd2};
  localparam logic [127:0] VLAST [3] = '{
    128'hd014f9a8c9ee2589e13f0cc8b6630ca6,
    128'he98ba06f448c773c8ecc720401002202,
    128'hfe4890d1e6188d0b046df344706c631e
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] cipher_key = '0;
  logic [1:0]   key_size = '0;
  logic         decrypt = 1'b0;
  logic         start = 1'b0;
  logic         step = 1'b0;
  logic [127:0] round_key;
  logic         rk_valid;

  int tests = 0;
  int fails = 0;
  logic [7:0]  sbt [256];
  logic [31:0] mw  [64];

  aes_rkey_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cipher_key(cipher_key), .key_size(key_size),
    .decrypt(decrypt), .start(start), .step(step),
    .round_key(round_key), .rk_valid(rk_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0; x = a;
    for (int n = 0; n < 8; n++) begin
      if (b[n]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [31:0] bsub(input logic [31:0] x);
    return {sbt[x[31:24]], sbt[x[23:16]], sbt[x[15:8]], sbt[x[7:0]]};
  endfunction

  function automatic logic [7:0] brc(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int m = 1; m < n; m++) r = bmul(r, 8'h02);
    return r;
  endfunction

  function automatic int nr_of(input logic [1:0] ks);
    return (ks == 2'd0) ? 10 : (ks == 2'd1) ? 12 : 14;
  endfunction

  task automatic build_sbox;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, s;
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int b = 0; b < 8; b++)
        s[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^
               inv[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
      sbt[x] = s;
    end
  endtask

  task automatic expand(input logic [255:0] k, input logic [1:0] ks);
    int n;
    logic [31:0] t;
    n = (ks == 2'd0) ? 4 : (ks == 2'd1) ? 6 : 8;
    for (int i = 0; i < n; i++) mw[i] = k[255-32*i -: 32];
    for (int i = n; i < 64; i++) begin
      t = mw[i-1];
      if (i % n == 0) t = bsub({t[23:0], t[31:24]}) ^ {brc(i / n), 24'h0};
      else if (n == 8 && i % 8 == 4) t = bsub(t);
      mw[i] = mw[i-n] ^ t;
    end
  endtask

  function automatic logic [127:0] rk(input int r);
    return {mw[4*r], mw[4*r+1], mw[4*r+2], mw[4*r+3]};
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_step;
    step = 1'b1;
    tick;
    step = 1'b0;
  endtask

  task automatic begin_run(input logic [255:0] k, input logic [1:0] ks,
                           input logic dec, output int lat);
    cipher_key = k; key_size = ks; decrypt = dec; start = 1'b1;
    tick;
    start = 1'b0;
    lat = 1;
    while (!rk_valid && lat < 40) begin
      tick;
      lat++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog (all requirements) got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat, nr;
    string tg;
    logic [255:0] k2;
    build_sbox;
    repeat (3) tick;
    chk("R1 valid in reset", 128'(rk_valid), 128'd0);
    rst_n = 1'b1;
    tick;
    tick;
    chk("R1 valid after reset", 128'(rk_valid), 128'd0);

    for (int v = 0; v < 3; v++) begin
      nr = nr_of(VSIZE[v]);
      tg = (v == 0) ? "R3" : (v == 1) ? "R4" : "R5";
      expand(VKEY[v], VSIZE[v]);
      chk({tg, " model final key"}, rk(nr), VLAST[v]);

      begin_run(VKEY[v], VSIZE[v], 1'b1, lat);
      chk("R7 miss latency", 128'(lat), 128'(nr + 1));
      chk("R7 miss final key", round_key, VLAST[v]);
      for (int r = nr - 1; r >= 0; r--) begin
        do_step;
        chk("R8 backward key", round_key, rk(r));
      end
      do_step;
      chk("R8 hold at round 0", round_key, rk(0));

      begin_run(VKEY[v], VSIZE[v], 1'b0, lat);
      chk("R2 enc latency", 128'(lat), 128'd1);
      chk("R2 round 0 key", round_key, rk(0));
      for (int r = 1; r <= nr; r++) begin
        do_step;
        chk({tg, " forward key"}, round_key, rk(r));
      end
      chk({tg, " final vs standard"}, round_key, VLAST[v]);
      do_step;
      chk("R6 hold at final", round_key, VLAST[v]);
      repeat (3) tick;
      chk("R11 idle hold key", round_key, VLAST[v]);
      chk("R11 idle hold valid", 128'(rk_valid), 128'd1);

      begin_run(VKEY[v], VSIZE[v], 1'b1, lat);
      chk("R9 hit latency", 128'(lat), 128'd1);
      chk("R9 hit final key", round_key, VLAST[v]);
      do_step;
      chk("R9 hit then back step", round_key, rk(nr - 1));
    end

    k2 = VKEY[2] ^ 256'h1;
    expand(k2, 2'd2);
    begin_run(k2, 2'd2, 1'b1, lat);
    chk("R10 used bit differs latency", 128'(lat), 128'd15);
    chk("R10 used bit differs key", round_key, rk(14));

    expand(VKEY[0], 2'd0);
    begin_run(VKEY[0], 2'd0, 1'b0, lat);
    for (int r = 1; r <= 10; r++) do_step;
    chk("R3 rerun final", round_key, VLAST[0]);
    k2 = {VKEY[0][255:128], 128'h0123456789abcdef_fedcba9876543210};
    begin_run(k2, 2'd0, 1'b1, lat);
    chk("R10 unused bits latency", 128'(lat), 128'd1);
    chk("R10 unused bits key", round_key, VLAST[0]);

    k2 = {VKEY[0][255:128], 64'h5555aaaa3333cccc, 64'h0};
    expand(k2, 2'd1);
    step = 1'b1;
    begin_run(k2, 2'd1, 1'b1, lat);
    step = 1'b0;
    chk("R10 size differs latency", 128'(lat), 128'd13);
    chk("R12 step during pre-expansion key", round_key, rk(12));
    do_step;
    chk("R12 first back step after pre-expansion", round_key, rk(11));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule